// File: doc/BRIEF.md
# Second-Operand Generator

This block forms the 32-bit second operand that a data-processing ALU consumes, together with the carry that a logical operation would write into the flags. It is purely combinational. Its inputs are a register value, the 12-bit operand field of the instruction, an immediate-select bit and the current carry flag.

The block has two paths that run in parallel. The register path is a five-stage barrel shifter. It supports logical left, logical right, arithmetic right and rotate right, and it takes its shift amount and kind from the upper bits of the operand field. The immediate path takes the low byte of the field and rotates it within its own eight bits, in either direction, by zero to seven places. It then widens the result with 24 zero bits. A 32-bit 2:1 selector driven by the immediate-select bit chooses which path reaches the ALU.

Field layout. On the register path, bits [11:7] give the shift amount and bits [6:5] give the shift kind. On the immediate path, bit 11 gives the rotate direction (1 = left, 0 = right), bits [10:8] give the rotate amount and bits [7:0] give the immediate byte.

Top module: `opgen_operand2`

## Requirements
- R1: With `imm_sel_i` = 1, `operand_o` equals the rotated immediate byte widened to 32 bits, and `carry_o` equals `carry_i`.
- R2: With `imm_sel_i` = 0, `operand_o` equals the register value shifted as directed by bits [11:5].
- R3: Shift kind 2'b00 (logical left) by n in 1..31 gives `reg_value_i << n`, with carry equal to register bit 32-n.
- R4: Shift kind 2'b01 (logical right) by n in 1..31 fills the top with zeros, with carry equal to register bit n-1.
- R5: Shift kind 2'b10 (arithmetic right) by n in 1..31 fills the top with copies of bit 31, with carry equal to register bit n-1.
- R6: Shift kind 2'b11 (rotate right) by n in 1..31 moves the low n bits to the top, with carry equal to register bit n-1.
- R7: A shift amount of zero passes the register value through unchanged for all four kinds, and `carry_o` equals `carry_i`.
- R8: On the immediate path, bit 11 = 1 rotates the byte left and bit 11 = 0 rotates it right, by the amount in bits [10:8]. An amount of zero leaves the byte unchanged.
- R9: On the immediate path, bits [31:8] of `operand_o` are always zero.
- R10: With `imm_sel_i` = 0, field bits [4:0] have no effect on `operand_o` or `carry_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_value_i | input | 32 | Register operand to be shifted |
| op_field_i | input | 12 | Operand field of the instruction |
| imm_sel_i | input | 1 | 1 selects the immediate path, 0 the register path |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The hardest case to reach is a carry taken from the extreme bit positions. Examples are a left shift by 31, which takes bit 1, and a right shift by 1 or 31. A wrong index at these ends only shows when that exact bit differs from its neighbours. The stimulus therefore sweeps every amount from 0 to 31 for all four kinds. The operands are zero, all ones, a lone bit 31, a lone bit 0 and random words, and both carry-in values are used. The low field bits are randomised on the register path so that any leak from them into the result is exposed.

// File: rtl/opgen_pkg.sv
package opgen_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned FIELD_W   = 12;
    localparam int unsigned IMM_W     = 8;

    // field positions decoded by the two paths
    localparam int unsigned SAMT_LSB  = 7;
    localparam int unsigned KIND_LSB  = 5;
    localparam int unsigned RDIR_BIT  = 11;
    localparam int unsigned RAMT_LSB  = 8;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/opgen_barrel.sv
module opgen_barrel
    import opgen_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  value_i,
    input  shift_kind_e   kind_i,
    input  logic [AW-1:0] amt_i,
    input  logic          carry_i,
    output logic [W-1:0]  value_o,
    output logic          carry_o
);
    logic [AW:0][W-1:0] stage;
    assign stage[0] = value_i;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int unsigned D = 1 << k;
        logic [W-1:0] nxt;
        always_comb begin
            nxt = stage[k];
            if (amt_i[k]) begin
                unique case (kind_i)
                    SH_LSL: nxt = {stage[k][W-1-D:0], {D{1'b0}}};
                    SH_LSR: nxt = {{D{1'b0}}, stage[k][W-1:D]};
                    SH_ASR: nxt = {{D{stage[k][W-1]}}, stage[k][W-1:D]};
                    SH_ROR: nxt = {stage[k][D-1:0], stage[k][W-1:D]};
                    default: nxt = stage[k];
                endcase
            end
        end
        assign stage[k+1] = nxt;
    end

    assign value_o = stage[AW];

    // carry picks the last bit to leave the word
    logic [AW-1:0] left_idx;
    logic [AW-1:0] right_idx;
    assign left_idx  = AW'(W) - amt_i;
    assign right_idx = amt_i - AW'(1);

    always_comb begin
        if (amt_i == '0)
            carry_o = carry_i;
        else if (kind_i == SH_LSL)
            carry_o = value_i[left_idx];
        else
            carry_o = value_i[right_idx];
    end

    always_comb begin
        // R7
        if (amt_i == '0) begin
            zero_pass_chk: assert (value_o == value_i && carry_o == carry_i)
                else $error("zero amount altered operand");
        end
        // R6
        if (kind_i == SH_ROR) begin
            ror_ones_chk: assert ($countones(value_o) == $countones(value_i))
                else $error("rotate changed bit count");
        end
        // R5
        if (kind_i == SH_ASR) begin
            asr_sign_chk: assert (value_o[W-1] == value_i[W-1])
                else $error("arithmetic shift lost sign");
        end
        // R4
        if (kind_i == SH_LSR && amt_i != '0) begin
            lsr_fill_chk: assert (value_o[W-1] == 1'b0)
                else $error("logical right shift filled with one");
        end
    end
endmodule

// File: rtl/opgen_byte_rot.sv
module opgen_byte_rot #(
    parameter int unsigned IW = opgen_pkg::IMM_W,
    parameter int unsigned OW = opgen_pkg::DATA_W,
    parameter int unsigned RW = $clog2(IW)
) (
    input  logic [IW-1:0] imm_i,
    input  logic          left_i,
    input  logic [RW-1:0] amt_i,
    output logic [OW-1:0] value_o
);
    logic [RW:0][IW-1:0] stage;
    assign stage[0] = imm_i;

    for (genvar k = 0; k < RW; k++) begin : g_stage
        localparam int unsigned D = 1 << k;
        logic [IW-1:0] nxt;
        always_comb begin
            nxt = stage[k];
            if (amt_i[k]) begin
                if (left_i)
                    nxt = {stage[k][IW-1-D:0], stage[k][IW-1:IW-D]};
                else
                    nxt = {stage[k][D-1:0], stage[k][IW-1:D]};
            end
        end
        assign stage[k+1] = nxt;
    end

    assign value_o = {{(OW-IW){1'b0}}, stage[RW]};

    always_comb begin
        // R9
        upper_zero_chk: assert (value_o[OW-1:IW] == '0)
            else $error("widened immediate has nonzero upper bits");
        // R8
        rot_ones_chk: assert ($countones(value_o) == $countones(imm_i))
            else $error("byte rotate changed bit count");
    end
endmodule

// File: rtl/opgen_sel.sv
module opgen_sel #(
    parameter int unsigned W = opgen_pkg::DATA_W
) (
    input  logic         imm_sel_i,
    input  logic [W-1:0] reg_path_i,
    input  logic         reg_carry_i,
    input  logic [W-1:0] imm_path_i,
    input  logic         carry_i,
    output logic [W-1:0] operand_o,
    output logic         carry_o
);
    assign operand_o = imm_sel_i ? imm_path_i : reg_path_i;
    assign carry_o   = imm_sel_i ? carry_i    : reg_carry_i;

    always_comb begin
        // R1
        if (imm_sel_i) begin
            imm_route_chk: assert (operand_o == imm_path_i && carry_o == carry_i)
                else $error("immediate path not routed");
        end
        // R2
        if (!imm_sel_i) begin
            reg_route_chk: assert (operand_o == reg_path_i && carry_o == reg_carry_i)
                else $error("register path not routed");
        end
    end
endmodule

// File: rtl/opgen_operand2.sv
module opgen_operand2
    import opgen_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned FW = FIELD_W,
    parameter int unsigned IW = IMM_W,
    localparam int unsigned SW = $clog2(DW),
    localparam int unsigned RW = $clog2(IW)
) (
    input  logic [DW-1:0] reg_value_i,
    input  logic [FW-1:0] op_field_i,
    input  logic          imm_sel_i,
    input  logic          carry_i,
    output logic [DW-1:0] operand_o,
    output logic          carry_o
);
    shift_kind_e   kind;
    logic [SW-1:0] shamt;
    logic [RW-1:0] rotamt;
    logic          rot_left;
    logic [IW-1:0] imm_byte;

    assign kind     = shift_kind_e'(op_field_i[KIND_LSB +: 2]);
    assign shamt    = op_field_i[SAMT_LSB +: SW];
    assign rotamt   = op_field_i[RAMT_LSB +: RW];
    assign rot_left = op_field_i[RDIR_BIT];
    assign imm_byte = op_field_i[IW-1:0];

    logic [DW-1:0] reg_path;
    logic          reg_carry;
    logic [DW-1:0] imm_path;

    opgen_barrel #(.W(DW), .AW(SW)) i_barrel (
        .value_i (reg_value_i),
        .kind_i  (kind),
        .amt_i   (shamt),
        .carry_i (carry_i),
        .value_o (reg_path),
        .carry_o (reg_carry)
    );

    opgen_byte_rot #(.IW(IW), .OW(DW), .RW(RW)) i_byte_rot (
        .imm_i   (imm_byte),
        .left_i  (rot_left),
        .amt_i   (rotamt),
        .value_o (imm_path)
    );

    opgen_sel #(.W(DW)) i_sel (
        .imm_sel_i   (imm_sel_i),
        .reg_path_i  (reg_path),
        .reg_carry_i (reg_carry),
        .imm_path_i  (imm_path),
        .carry_i     (carry_i),
        .operand_o   (operand_o),
        .carry_o     (carry_o)
    );
endmodule

// File: tb/test_opgen_operand2.sv
module test_opgen_operand2;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic        clk = 1'b0;
    logic [31:0] reg_value;
    logic [11:0] op_field;
    logic        imm_sel;
    logic        carry_in;
    logic [31:0] operand;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opgen_operand2 i_opgen_operand2 (
        .reg_value_i (reg_value),
        .op_field_i  (op_field),
        .imm_sel_i   (imm_sel),
        .carry_i     (carry_in),
        .operand_o   (operand),
        .carry_o     (carry_out)
    );

    typedef struct packed {
        logic        sel;
        logic [11:0] fld;
        logic [31:0] rv;
        logic        cin;
        logic [31:0] eout;
        logic        ecar;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h200, 32'h8000_000F, 1'b0, 32'h0000_00F0, 1'b0},
        '{1'b0, 12'h0A0, 32'h0000_0003, 1'b0, 32'h0000_0001, 1'b1},
        '{1'b0, 12'hFC0, 32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b0},
        '{1'b0, 12'h460, 32'h1234_5678, 1'b1, 32'h7812_3456, 1'b0},
        '{1'b0, 12'h01F, 32'hDEAD_BEEF, 1'b1, 32'hDEAD_BEEF, 1'b1},
        '{1'b1, 12'h181, 32'hFFFF_FFFF, 1'b1, 32'h0000_00C0, 1'b1},
        '{1'b1, 12'hBF0, 32'h0000_0000, 1'b0, 32'h0000_0087, 1'b0},
        '{1'b1, 12'h8A5, 32'h1234_5678, 1'b1, 32'h0000_00A5, 1'b1},
        '{1'b0, 12'h080, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}
    };
    localparam string TAGS [NVEC] = '{"R3", "R4", "R5", "R6", "R7", "R8", "R8", "R8", "R3"};

    // bit-at-a-time reference: returns {carry, value}
    function automatic logic [32:0] ref_shift(input logic [31:0] v, input logic [1:0] kd,
                                              input int n, input logic cin);
        logic c = cin;
        for (int i = 0; i < n; i++) begin
            case (kd)
                2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    function automatic logic [31:0] ref_imm(input logic [7:0] b, input logic left, input int n);
        for (int i = 0; i < n; i++)
            b = left ? {b[6:0], b[7]} : {b[0], b[7:1]};
        return {24'h0, b};
    endfunction

    task automatic apply_check(input string tag, input logic sel, input logic [11:0] fld,
                               input logic [31:0] rv, input logic cin,
                               input logic [31:0] eout, input logic ecar);
        @(negedge clk);
        imm_sel = sel; op_field = fld; reg_value = rv; carry_in = cin;
        #(CLK_PERIOD/4);
        checks++;
        if (operand !== eout || carry_out !== ecar) begin
            errors++;
            $display("FAIL %s: field=%h rv=%h got %h/%b expected %h/%b",
                     tag, fld, rv, operand, carry_out, eout, ecar);
        end
    endtask

    function automatic string kind_tag(input logic [1:0] kd, input int n);
        if (n == 0) return "R7";
        case (kd)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ops [8];
        imm_sel = 1'b0; op_field = '0; reg_value = '0; carry_in = 1'b0;

        // idle inputs: all zero gives zero operand, carry follows input (R7)
        apply_check("R7", 1'b0, 12'h000, 32'h0, 1'b0, 32'h0, 1'b0);

        // vector table (R1 routing covered by the immediate rows, R2 by register rows)
        for (int v = 0; v < NVEC; v++)
            apply_check(TAGS[v], VECS[v].sel, VECS[v].fld, VECS[v].rv, VECS[v].cin,
                        VECS[v].eout, VECS[v].ecar);

        ops[0] = 32'h0; ops[1] = 32'hFFFF_FFFF; ops[2] = 32'h8000_0000; ops[3] = 32'h1;
        for (int r = 4; r < 8; r++) ops[r] = $urandom;

        // register path sweep, low field bits randomised (R2, R10)
        for (int kd = 0; kd < 4; kd++)
            for (int n = 0; n < 32; n++)
                for (int o = 0; o < 8; o++)
                    for (int c = 0; c < 2; c++) begin
                        logic [32:0] exp;
                        logic [4:0]  junk = 5'($urandom);
                        exp = ref_shift(ops[o], 2'(kd), n, 1'(c));
                        apply_check(kind_tag(2'(kd), n), 1'b0, {5'(n), 2'(kd), junk},
                                    ops[o], 1'(c), exp[31:0], exp[32]);
                    end

        // R10: same shift, two different low-bit patterns, identical result
        apply_check("R10", 1'b0, {5'd3, 2'b01, 5'b00000}, 32'hF000_0008, 1'b0, 32'h1E00_0001, 1'b0);
        apply_check("R10", 1'b0, {5'd3, 2'b01, 5'b11111}, 32'hF000_0008, 1'b0, 32'h1E00_0001, 1'b0);

        // immediate path sweep: every direction and amount (R1, R8, R9)
        for (int dir = 0; dir < 2; dir++)
            for (int n = 0; n < 8; n++)
                for (int b = 0; b < 6; b++)
                    for (int c = 0; c < 2; c++) begin
                        logic [7:0] byt;
                        case (b)
                            0: byt = 8'h00; 1: byt = 8'hFF; 2: byt = 8'h80; 3: byt = 8'h01;
                            default: byt = 8'($urandom);
                        endcase
                        apply_check((b == 1) ? "R9" : ((n == 0) ? "R8" : "R1"), 1'b1,
                                    {1'(dir), 3'(n), byt}, $urandom, 1'(c),
                                    ref_imm(byt, 1'(dir), n), 1'(c));
                    end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule